// File: doc/BRIEF.md
# Two-Phase Fork/Join Handshake Controller

This block is the handshake glue that lets a two-phase, bundled-data latch pipeline split into parallel branches and merge them again. Its fork side hands one producer's data word and request to several branch stages at once. It returns a single acknowledge to the producer, and that acknowledge toggles only when every branch has acknowledged. Its join side waits until every branch has toggled its request. It then latches the branch words side by side into one destination stage, and it presents one request to the consumer.

Every req and ack wire uses transition signalling: a toggle in either direction marks one data item. Both merge points are Muller C-elements that hold their state and reset to 0. A C-element output takes the shared value of its inputs when they all agree, and otherwise keeps its last value. The join's destination stage follows the usual phase-converting latch rule. It captures when its own done state matches the consumer's ack, and it stays closed until the consumer acknowledges. The asynchronous behaviour is modelled with clocked storage so that it fits a synchronous flow.

Top module: `tpfj_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `src_ack`, `jack_out` and `dst_req` are 0 and `dst_data` is all zeros.
- R2: In the same cycle, every bit of `brq_out` equals `src_req` and `bdata_out` equals `src_data`, with no register between them.
- R3: `src_ack` takes value v one clock edge after every bit of `back_in` equals v. While the bits of `back_in` disagree, `src_ack` keeps its value, so an early branch cannot advance the producer.
- R4: The join's merged request takes value v one edge after every bit of `jrq_in` equals v. While the bits of `jrq_in` disagree, `dst_req` does not move.
- R5: When the merged request differs from `dst_req` and `dst_req` equals `dst_ack`, the next edge copies the merged request into `dst_req` and loads `dst_data` from `jdata_in`. Branch i occupies bits [i*W +: W], with branch 0 at the least significant end. From the last branch toggle to `dst_req` moving takes two edges. `dst_data` changes only together with `dst_req`.
- R6: While `dst_req` differs from `dst_ack`, the destination stage is closed: `dst_req` and `dst_data` hold, even if new branch requests and data arrive.
- R7: `jack_out`, the acknowledge shared by all branches, equals `dst_req`, so it toggles once per captured item.
- R8: A fork into two branches of unequal, varying latency followed by the join delivers every producer word d, in order, as the pair {d, d}. The loop never deadlocks, whatever the branch and consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_req | input | 1 | Producer request (transition) |
| src_data | input | W | Producer data word |
| src_ack | output | 1 | Merged branch acknowledge to producer |
| brq_out | output | NB | Request to each fork branch |
| bdata_out | output | W | Data broadcast to all fork branches |
| back_in | input | NB | Acknowledge from each fork branch |
| jrq_in | input | NB | Request from each join branch |
| jdata_in | input | NB*W | Branch data words, branch i at [i*W +: W] |
| jack_out | output | 1 | Acknowledge shared by all join branches |
| dst_req | output | 1 | Request to the consumer |
| dst_data | output | NB*W | Captured, concatenated branch words |
| dst_ack | input | 1 | Consumer acknowledge (transition) |

## Verification
The assertions check the local handshake rules on every cycle. Either C-element output may move only to a value that all of its inputs held on the previous edge. `dst_req` may change only to the merged request, and only while the stage is open. `dst_data` never changes without a request toggle. Other properties need whole scenarios from the bench: correct lane order in the captured word, exact edge latencies, holding of a second item while the consumer stalls, and in-order, deadlock-free delivery of paired words through branches with unequal, changing delays.

// File: rtl/tpfj_pkg.sv
package tpfj_pkg;
  // Next state of a Muller C-element given whether all inputs are high/low.
  function automatic logic c_step(input logic all_hi, input logic all_lo,
                                  input logic prev);
    if (all_hi) return 1'b1;
    if (all_lo) return 1'b0;
    return prev;
  endfunction
endpackage

// File: rtl/tpfj_celem.sv
module tpfj_celem #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ins,
  output logic         out
);
  import tpfj_pkg::*;
  logic agree_hi, agree_lo;
  assign agree_hi = &ins;
  assign agree_lo = ~|ins;

  always_ff @(posedge clk) begin
    if (!rst_n) out <= 1'b0;
    else        out <= c_step(agree_hi, agree_lo, out);
  end
endmodule

// File: rtl/tpfj_fork.sv
module tpfj_fork #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_req,
  input  logic [W-1:0]  src_data,
  input  logic [NB-1:0] back_in,
  output logic [NB-1:0] brq_out,
  output logic [W-1:0]  bdata_out,
  output logic          merged_ack
);
  // Request and data fan out unchanged to every branch.
  for (genvar b = 0; b < NB; b++) begin : g_req
    assign brq_out[b] = src_req;
  end
  assign bdata_out = src_data;

  // Producer sees one ack, released only by the slowest branch.
  tpfj_celem #(.N(NB)) u_ack_merge (
    .clk(clk), .rst_n(rst_n), .ins(back_in), .out(merged_ack)
  );
endmodule

// File: rtl/tpfj_join.sv
module tpfj_join #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB-1:0]   jrq_in,
  input  logic [NB*W-1:0] jdata_in,
  input  logic            dst_ack,
  output logic            merged_req,
  output logic            capture_en,
  output logic            done,
  output logic [NB*W-1:0] held_data
);
  tpfj_celem #(.N(NB)) u_req_merge (
    .clk(clk), .rst_n(rst_n), .ins(jrq_in), .out(merged_req)
  );

  // Phase converter: open while done matches downstream ack,
  // capture when a fresh merged request is present.
  assign capture_en = (done == dst_ack) && (merged_req != done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done      <= 1'b0;
      held_data <= '0;
    end else if (capture_en) begin
      done      <= merged_req;
      held_data <= jdata_in;
    end
  end
endmodule

// File: rtl/tpfj_top.sv
module tpfj_top #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            src_req,
  input  logic [W-1:0]    src_data,
  output logic            src_ack,
  output logic [NB-1:0]   brq_out,
  output logic [W-1:0]    bdata_out,
  input  logic [NB-1:0]   back_in,
  input  logic [NB-1:0]   jrq_in,
  input  logic [NB*W-1:0] jdata_in,
  output logic            jack_out,
  output logic            dst_req,
  output logic [NB*W-1:0] dst_data,
  input  logic            dst_ack
);
  localparam int DW = NB * W;

  logic          fork_merged_ack;
  logic          join_merged_req;
  logic          join_capture;
  logic          join_done;
  logic [DW-1:0] join_held;

  tpfj_fork #(.NB(NB), .W(W)) u_fork (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_data(src_data),
    .back_in(back_in), .brq_out(brq_out), .bdata_out(bdata_out),
    .merged_ack(fork_merged_ack)
  );

  tpfj_join #(.NB(NB), .W(W)) u_join (
    .clk(clk), .rst_n(rst_n), .jrq_in(jrq_in), .jdata_in(jdata_in),
    .dst_ack(dst_ack), .merged_req(join_merged_req),
    .capture_en(join_capture), .done(join_done), .held_data(join_held)
  );

  assign src_ack  = fork_merged_ack;
  assign dst_req  = join_done;
  assign jack_out = join_done;
  assign dst_data = join_held;
endmodule

// File: rtl/tpfj_checker.sv
module tpfj_checker #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            src_ack,
  input logic [NB-1:0]   back_in,
  input logic [NB-1:0]   jrq_in,
  input logic            join_merged_req,
  input logic            dst_req,
  input logic            dst_ack,
  input logic [NB*W-1:0] dst_data
);
  assert_fork_ack_needs_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_ack) |-> ($past(back_in) == {NB{src_ack}}));

  assert_join_req_needs_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(join_merged_req) |-> ($past(jrq_in) == {NB{join_merged_req}}));

  assert_capture_follows_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dst_req) |-> ($past(join_merged_req) == dst_req));

  assert_data_moves_with_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dst_data) |-> !$stable(dst_req));

  assert_closed_stage_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dst_req != dst_ack) |-> ($stable(dst_req) && $stable(dst_data)));
endmodule

bind tpfj_top tpfj_checker #(.NB(NB), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_ack(src_ack), .back_in(back_in),
  .jrq_in(jrq_in), .join_merged_req(join_merged_req), .dst_req(dst_req),
  .dst_ack(dst_ack), .dst_data(dst_data)
);

// File: tb/tpfj_top_bench.sv
module tpfj_top_bench;
  localparam int NB = 2;
  localparam int W  = 8;
  localparam int NITEMS = 40;
  localparam int NVEC = 10;
  // {data[19:12], branch0 delay[11:8], branch1 delay[7:4], consumer stall[3:0]}
  localparam logic [19:0] VEC [NVEC] = '{
    20'hA5_0_0_0, 20'h3C_0_5_1, 20'h71_6_0_0, 20'hFF_2_9_3, 20'h00_9_2_0,
    20'h18_1_1_7, 20'hC3_0_8_2, 20'h5A_7_7_0, 20'h96_3_0_5, 20'h42_0_3_0
  };

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic rst_n = 0;
  logic src_req = 0;
  logic [W-1:0] src_data = 0;
  logic src_ack;
  logic [NB-1:0] brq_out;
  logic [W-1:0] bdata_out;
  logic bk0 = 0, bk1 = 0, jr0 = 0, jr1 = 0;
  logic [W-1:0] jd0 = 0, jd1 = 0;
  logic jack_out, dst_req;
  logic [NB*W-1:0] dst_data;
  logic dst_ack = 0;

  logic man_bk_en = 0;
  logic [NB-1:0] man_bk = 0, man_jr = 0;
  logic [NB*W-1:0] man_jd = 0;
  logic auto_on = 0;

  wire [NB-1:0]   back_in  = man_bk_en ? man_bk : {bk1, bk0};
  wire [NB-1:0]   jrq_in   = man_bk_en ? man_jr : {jr1, jr0};
  wire [NB*W-1:0] jdata_in = man_bk_en ? man_jd : {jd1, jd0};

  tpfj_top #(.NB(NB), .W(W)) u_tpfj_top (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_data(src_data),
    .src_ack(src_ack), .brq_out(brq_out), .bdata_out(bdata_out),
    .back_in(back_in), .jrq_in(jrq_in), .jdata_in(jdata_in),
    .jack_out(jack_out), .dst_req(dst_req), .dst_data(dst_data),
    .dst_ack(dst_ack)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] sent [NITEMS];
  int dl0 [NITEMS], dl1 [NITEMS], dlc [NITEMS];
  int rcv = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Branch 0 model: take item when join has consumed previous one.
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (auto_on && (brq_out[0] != bk0) && (jr0 == jack_out) && k < NITEMS) begin
        logic [W-1:0] d;
        d = bdata_out;
        repeat (dl0[k]) @(negedge clk);
        jd0 = d; jr0 = ~jr0; bk0 = ~bk0;
        k++;
      end
    end
  end

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (auto_on && (brq_out[1] != bk1) && (jr1 == jack_out) && k < NITEMS) begin
        logic [W-1:0] d;
        d = bdata_out;
        repeat (dl1[k]) @(negedge clk);
        jd1 = d; jr1 = ~jr1; bk1 = ~bk1;
        k++;
      end
    end
  end

  // Consumer: checks pairing and order (R8).
  initial begin
    forever begin
      @(negedge clk);
      if (auto_on && (dst_req != dst_ack) && rcv < NITEMS) begin
        check("R8 paired in-order output", dst_data, {sent[rcv], sent[rcv]});
        repeat (dlc[rcv]) @(negedge clk);
        rcv++;
        dst_ack = ~dst_ack;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL R8 watchdog expired: received=%0d expected=%0d", rcv, NITEMS);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    man_bk_en = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 src_ack in reset", src_ack, 0);
    check("R1 dst_req in reset", dst_req, 0);
    check("R1 dst_data in reset", dst_data, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 jack_out after reset", jack_out, 0);

    // R2 fork broadcast
    src_data = 8'h6E; src_req = 1; #1;
    check("R2 branch requests", brq_out, 2'b11);
    check("R2 branch data", bdata_out, 8'h6E);
    // R3 one early branch must not release producer
    @(negedge clk); man_bk = 2'b01;
    repeat (3) @(negedge clk);
    check("R3 early branch holds src_ack", src_ack, 0);
    man_bk = 2'b11;
    @(negedge clk);
    check("R3 src_ack after all branches", src_ack, 1);

    // R4 partial join does not fire
    man_jd = 16'hB2_4D; man_jr = 2'b01;
    repeat (3) @(negedge clk);
    check("R4 partial join holds dst_req", dst_req, 0);
    man_jr = 2'b11;
    @(negedge clk);
    check("R5 one edge: not yet captured", dst_req, 0);
    @(negedge clk);
    check("R5 two edges: dst_req", dst_req, 1);
    check("R5 lane order", dst_data, 16'hB2_4D);
    check("R7 jack_out follows dst_req", jack_out, 1);

    // R6 second item while consumer stalls
    man_jd = 16'h19_E7; man_jr = 2'b00;
    repeat (3) @(negedge clk);
    check("R6 stalled dst_req", dst_req, 1);
    check("R6 stalled dst_data", dst_data, 16'hB2_4D);
    dst_ack = 1;
    @(negedge clk);
    check("R6 release captures next", dst_req, 0);
    check("R6 release data", dst_data, 16'h19_E7);
    check("R7 jack_out toggles back", jack_out, 0);

    // Reset back to idle before the end-to-end run
    rst_n = 0; src_req = 0; src_data = 0; dst_ack = 0;
    man_bk = 0; man_jr = 0; man_jd = 0;
    repeat (2) @(negedge clk);
    check("R1 reset clears dst_data", dst_data, 0);
    man_bk_en = 0;
    rst_n = 1;
    @(negedge clk);

    // Vector table then random stalls (R8)
    for (int k = 0; k < NITEMS; k++) begin
      if (k < NVEC) begin
        sent[k] = VEC[k][19:12];
        dl0[k]  = int'(VEC[k][11:8]);
        dl1[k]  = int'(VEC[k][7:4]);
        dlc[k]  = int'(VEC[k][3:0]);
      end else begin
        sent[k] = W'(k * 37 + 5);
        dl0[k]  = int'($urandom_range(0, 6));
        dl1[k]  = int'($urandom_range(0, 6));
        dlc[k]  = int'($urandom_range(0, 4));
      end
    end
    auto_on = 1;
    for (int k = 0; k < NITEMS; k++) begin
      while (src_ack != src_req) @(negedge clk);
      src_data = sent[k];
      src_req = ~src_req;
      @(negedge clk);
    end
    while (rcv < NITEMS) @(negedge clk);
    check("R8 all items delivered", rcv, NITEMS);
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule